// File: doc/BRIEF.md
# Tiled View Address Generator

This block converts a pixel coordinate into an address in a tiled address space. Each request carries a pixel format, a view orientation and an X/Y pair. The block checks the coordinate against the range allowed for that format. It then applies mirroring along either axis and, if asked, swaps the axes. It packs the resulting linear index into the low address bits and places the format and orientation codes in the top bits. Alongside the address it reports the line stride that a client should use when it walks the same view line by line.

A client pulses a request strobe with the inputs. One clock later the address, the stride and a valid flag appear on registered outputs. The outputs keep those values until the next request arrives. The container width and height bit counts and the page-mode slot bit counts are parameters. The index field therefore always fills exactly the bits below the format field when the two container counts add up to 27.

Top module: `tiled_view_addr`

## Requirements
- R1: For an in-range coordinate, address bits [28:27] carry the format code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page mode.
- R2: For an in-range coordinate, address bits [31:29] carry the 3-bit orientation code unchanged.
- R3: The format selects an X and Y shift: 8-bit (0,0), 16-bit (0,1), 32-bit (1,1), page mode (slot width bits, slot height bits). The X coordinate width is the container width bits minus the X shift, and the Y width is the container height bits minus the Y shift.
- R4: If X exceeds its all-ones mask or Y exceeds its all-ones mask, the whole address is zero.
- R5: Orientation bit 0 replaces X by X XOR the X mask. Orientation bit 1 replaces Y by Y XOR the Y mask. Both happen before any swap.
- R6: With orientation bit 2 set, the index is (X shifted left by the Y width) plus Y. With bit 2 clear, it is (Y shifted left by the X width) plus X.
- R7: The index is shifted left by the sum of the X and Y shifts and placed in address bits [26:0].
- R8: The stride output is 2^(container height bits + X shift) when orientation bit 2 is set, and 2^(container width bits + Y shift) otherwise. This holds whether or not the coordinate is in range.
- R9: The valid flag is high exactly in the cycle after a request strobe. Address and stride change only on the edge that samples a strobe and hold otherwise.
- R10: After reset, valid, address and stride are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 1 | Request strobe; inputs sampled on this edge |
| fmtIn | input | 2 | Pixel format code |
| orientIn | input | 3 | View orientation code (bit0 X-invert, bit1 Y-invert, bit2 swap) |
| xIn | input | COORD_W | X coordinate |
| yIn | input | COORD_W | Y coordinate |
| validOut | output | 1 | Result valid, one cycle after reqIn |
| addrOut | output | 32 | Tiled address |
| strideOut | output | 32 | Line stride in bytes of address space |

## Verification
The assertions assume that reqIn, fmtIn, orientIn and the coordinates carry known values on every clock after reset. They also assume that every 2-bit format and 3-bit orientation code is legal, so none of the codes is treated as reserved. The stimulus sweeps all format and orientation codes on a small container. For each code pair it drives X and Y from zero to just past the widest mask, so every format meets both its last legal coordinate and its first illegal one. Idle cycles after the sweep exercise the hold and valid-drop rules.

// File: rtl/tva_pkg.sv
package tva_pkg;
  typedef enum logic [1:0] {
    FMT_8  = 2'd0,
    FMT_16 = 2'd1,
    FMT_32 = 2'd2,
    FMT_PG = 2'd3
  } fmtT;

  typedef struct packed {
    logic capture;
  } ctrlT;

  localparam int ADDR_W   = 32;
  localparam int FIELD_LSB = 27;
endpackage

// File: rtl/tva_ctrl.sv
module tva_ctrl
  import tva_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqIn,
  output ctrlT ctrl,
  output logic validOut
);
  logic validQ;

  always_comb ctrl.capture = reqIn;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= reqIn;
  end

  assign validOut = validQ;
endmodule

// File: rtl/tva_datapath.sv
module tva_datapath
  import tva_pkg::*;
#(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int COORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlT                 ctrl,
  input  logic [1:0]           fmtIn,
  input  logic [2:0]           orientIn,
  input  logic [COORD_W-1:0]   xIn,
  input  logic [COORD_W-1:0]   yIn,
  output logic [ADDR_W-1:0]    addrOut,
  output logic [ADDR_W-1:0]    strideOut
);
  localparam int IDX_W = FIELD_LSB;
  localparam logic [5:0] CW6 = 6'(CW_BITS);
  localparam logic [5:0] CH6 = 6'(CH_BITS);

  logic [5:0]        shX, shY, xBits, yBits;
  logic [31:0]       xMask, yMask, xExt, yExt, xMir, yMir, lin;
  logic [IDX_W-1:0]  idxShift;
  logic              inRange;
  logic [ADDR_W-1:0] addrNext, strideNext;

  always_comb begin
    unique case (fmtT'(fmtIn))
      FMT_8:   begin shX = 6'd0;        shY = 6'd0;        end
      FMT_16:  begin shX = 6'd0;        shY = 6'd1;        end
      FMT_32:  begin shX = 6'd1;        shY = 6'd1;        end
      default: begin shX = 6'(SW_BITS); shY = 6'(SH_BITS); end
    endcase
    xBits = CW6 - shX;
    yBits = CH6 - shY;
    xMask = (32'd1 << xBits) - 32'd1;
    yMask = (32'd1 << yBits) - 32'd1;
    xExt  = 32'(xIn);
    yExt  = 32'(yIn);
    inRange = (xExt <= xMask) && (yExt <= yMask);
    xMir = orientIn[0] ? (xExt ^ xMask) : xExt;
    yMir = orientIn[1] ? (yExt ^ yMask) : yExt;
    lin  = orientIn[2] ? ((xMir << yBits) + yMir) : ((yMir << xBits) + xMir);
    idxShift = IDX_W'(lin << (shX + shY));
    addrNext = inRange ? {orientIn, fmtIn, idxShift} : '0;
    strideNext = orientIn[2] ? (32'd1 << (CH6 + shX)) : (32'd1 << (CW6 + shY));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut   <= '0;
      strideOut <= '0;
    end else if (ctrl.capture) begin
      addrOut   <= addrNext;
      strideOut <= strideNext;
    end
  end
endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr
  import tva_pkg::*;
#(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int COORD_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqIn,
  input  logic [1:0]         fmtIn,
  input  logic [2:0]         orientIn,
  input  logic [COORD_W-1:0] xIn,
  input  logic [COORD_W-1:0] yIn,
  output logic               validOut,
  output logic [31:0]        addrOut,
  output logic [31:0]        strideOut
);
  ctrlT ctrl;

  tva_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .ctrl(ctrl), .validOut(validOut)
  );

  tva_datapath #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .SW_BITS(SW_BITS),
    .SH_BITS(SH_BITS), .COORD_W(COORD_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .fmtIn(fmtIn), .orientIn(orientIn),
    .xIn(xIn), .yIn(yIn), .addrOut(addrOut), .strideOut(strideOut)
  );
endmodule

// File: rtl/tiled_view_addr_checks.sv
module tiled_view_addr_checks #(
  parameter int CW_BITS = 14,
  parameter int COORD_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqIn,
  input logic [1:0]         fmtIn,
  input logic [2:0]         orientIn,
  input logic [COORD_W-1:0] xIn,
  input logic               validOut,
  input logic [31:0]        addrOut,
  input logic [31:0]        strideOut
);
  localparam logic [31:0] X_LIMIT = 32'd1 << CW_BITS;

  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqIn |=> validOut);
  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqIn |=> !validOut);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqIn |=> ($stable(addrOut) && $stable(strideOut)));
  assert_stride_pow2_R8: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> ($countones(strideOut) == 1));
  assert_fmt_field_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqIn |=> (addrOut == 32'd0 || addrOut[28:27] == $past(fmtIn)));
  assert_orient_field_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqIn |=> (addrOut == 32'd0 || addrOut[31:29] == $past(orientIn)));
  assert_wide_x_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn && (32'(xIn) >= X_LIMIT)) |=> (addrOut == 32'd0));
endmodule

bind tiled_view_addr tiled_view_addr_checks #(
  .CW_BITS(CW_BITS), .COORD_W(COORD_W)
) uChecks (
  .clk(clk), .rstN(rstN), .reqIn(reqIn), .fmtIn(fmtIn), .orientIn(orientIn),
  .xIn(xIn), .validOut(validOut), .addrOut(addrOut), .strideOut(strideOut)
);

// File: tb/tiled_view_addr_test.sv
module tiled_view_addr_test;
  localparam int CW = 6;
  localparam int CH = 5;
  localparam int SW = 2;
  localparam int SH = 2;
  localparam int CWID = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqIn = 1'b0;
  logic [1:0] fmtIn = '0;
  logic [2:0] orientIn = '0;
  logic [CWID-1:0] xIn = '0;
  logic [CWID-1:0] yIn = '0;
  logic validOut;
  logic [31:0] addrOut, strideOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tiled_view_addr #(
    .CW_BITS(CW), .CH_BITS(CH), .SW_BITS(SW), .SH_BITS(SH), .COORD_W(CWID)
  ) uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .fmtIn(fmtIn), .orientIn(orientIn),
    .xIn(xIn), .yIn(yIn), .validOut(validOut), .addrOut(addrOut),
    .strideOut(strideOut)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_vals(input int f, input int o, input int x, input int y,
                             output longint ea, output longint es);
    int xs, ys, xb, yb;
    longint xmax, ymax, xm, ym, idx;
    case (f)
      0: begin xs = 0; ys = 0; end
      1: begin xs = 0; ys = 1; end
      2: begin xs = 1; ys = 1; end
      default: begin xs = SW; ys = SH; end
    endcase
    xb = CW - xs;
    yb = CH - ys;
    xmax = (longint'(1) << xb) - 1;
    ymax = (longint'(1) << yb) - 1;
    es = (o >= 4) ? (longint'(1) << (CH + xs)) : (longint'(1) << (CW + ys));
    if (x > xmax || y > ymax) begin
      ea = 0;
    end else begin
      xm = (o % 2 == 1) ? xmax - x : x;
      ym = ((o / 2) % 2 == 1) ? ymax - y : y;
      idx = (o >= 4) ? xm * (longint'(1) << yb) + ym : ym * (longint'(1) << xb) + xm;
      idx = idx * (longint'(1) << (xs + ys));
      ea = longint'(o) * (longint'(1) << 29) + longint'(f) * (longint'(1) << 27) + idx;
    end
  endtask

  initial begin
    longint ea, es;
    logic [31:0] heldA, heldS;
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    chk(validOut == 1'b0, "R10 valid", validOut, 0);
    chk(addrOut == 32'd0, "R10 addr", addrOut, 0);
    chk(strideOut == 32'd0, "R10 stride", strideOut, 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int f = 0; f < 4; f++) begin
      for (int o = 0; o < 8; o++) begin
        for (int x = 0; x <= (1 << CW) + 1; x++) begin
          for (int y = 0; y <= (1 << CH) + 1; y++) begin
            @(negedge clk);
            reqIn = 1'b1;
            fmtIn = 2'(f);
            orientIn = 3'(o);
            xIn = CWID'(x);
            yIn = CWID'(y);
            @(posedge clk);
            #2;
            expect_vals(f, o, x, y, ea, es);
            chk(validOut == 1'b1, "R9 valid", validOut, 1);
            if (ea == 0) begin
              chk(addrOut == 32'd0, "R4 out of range", addrOut, ea);
            end else begin
              chk(addrOut[28:27] == 2'(f), "R1 format field", addrOut[28:27], f);
              chk(addrOut[31:29] == 3'(o), "R2 orient field", addrOut[31:29], o);
              chk(addrOut[26:0] == 27'(ea), "R3 R5 R6 R7 index", addrOut[26:0], ea % (1 << 27));
            end
            chk(strideOut == 32'(es), "R8 stride", strideOut, es);
          end
        end
      end
    end
    heldA = addrOut;
    heldS = strideOut;
    @(negedge clk);
    reqIn = 1'b0;
    xIn = 8'd3;
    fmtIn = 2'd2;
    orientIn = 3'd5;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #2;
      chk(validOut == 1'b0, "R9 valid drop", validOut, 0);
      chk(addrOut == heldA, "R9 addr hold", addrOut, heldA);
      chk(strideOut == heldS, "R9 stride hold", strideOut, heldS);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule